// File: doc/BRIEF.md
# Sleep-Mode Power Sequencer

This block moves a design into a low-power sleep state and back out again. It owns two sets of controls. The first is a bank of 16 global clock enables. The second is a single I/O enable line; when that line is low, the output buffers are tri-stated and the input buffers are powered down. The block runs from a free-running oscillator clock. A level-sensitive sleep request starts each change of state.

Going to sleep, the I/O line drops first. After a programmable wait, the clock enables are removed in three fixed groups, starting at the low bits. Waking up runs the same steps in reverse: the clock groups come back first, low bits first, and after a second wait the I/O line returns. Four 6-bit settings time the four waits. A setting below its safe floor is raised to that floor. A status output covers the whole interval from the first step of entry to the last step of exit. It tells the surrounding logic that its clocks are, or may soon be, stopped.

Top module: `pmc_sleep_ctrl`

## Requirements
- R1: While reset is asserted and just after it, clk_ena is all ones, ioe is 1, sleep_status is 0 and the controller is awake.
- R2: When awake with sleep_req low, the outputs stay at clk_ena all ones, ioe 1 and sleep_status 0. When asleep with sleep_req high, they stay at clk_ena all zeros, ioe 0 and sleep_status 1.
- R3: If sleep_req is 1 when sampled at rising edge k while awake, ioe goes to 0 at edge k+T1. At edge k+T1+T2, bits [5:0] of clk_ena clear. At edge k+T1+T2+1, bits [10:6] clear. At edge k+T1+T2+2, bits [15:11] clear and the controller is asleep.
- R4: If sleep_req is 0 when sampled at rising edge m while asleep, bits [5:0] of clk_ena set at edge m+T3. Bits [10:6] set at edge m+T3+1, and bits [15:11] set at edge m+T3+2. At edge m+T3+2+T4, ioe returns to 1 and the controller is awake.
- R5: sleep_status rises at the edge where entry starts. It falls at the edge where ioe returns at the end of exit, and at no other time.
- R6: Each timing input is raised to its floor before use. The floors are 1 for T1 (t_io_off), 11 for T2 (t_clk_off), 1 for T3 (t_clk_on) and 40 for T4 (t_io_on). A value of 63 gives a 63-cycle wait.
- R7: Changes on sleep_req while a sequence runs have no effect on it. The request is sampled again on the first edge after the controller reaches the sleep or awake state.
- R8: ioe falls only while all clock enables are set. ioe rises only after all clock enables have been restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Level request: 1 asks for sleep, 0 asks for awake |
| t_io_off | input | 6 | T1: cycles from request to I/O off |
| t_clk_off | input | 6 | T2: cycles from I/O off to first clock group removed |
| t_clk_on | input | 6 | T3: cycles from wake request to first clock group restored |
| t_io_on | input | 6 | T4: cycles from last clock group restored to I/O on |
| clk_ena | output | 16 | Global clock enables, 1 = running |
| ioe | output | 1 | I/O enable, 0 = buffers tri-stated and powered down |
| sleep_status | output | 1 | High from the start of entry to the end of exit |

## Verification
The hardest case to reach from the ports is a request that reverses while a sequence is still running. To reach it, the stimulus drops sleep_req a few cycles into an entry and raises it again partway through an exit. A correct controller must finish the running sequence and then turn around on the very next edge. The bench also drives all-zero timing values and all-63 values, so the floors and the longest waits are both hit, and the per-cycle model checks the exact edge of every group step.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_EXIT  = 2'd3
  } pmc_state_e;

  typedef enum logic [1:0] {
    PH_WAIT_A = 2'd0,
    PH_WAIT_B = 2'd1,
    PH_RAMP   = 2'd2
  } pmc_phase_e;

  localparam int NUM_GRP = 3;

  // group index of one clock-enable bit given the two group start bits
  function automatic int group_of(input int bit_idx, input int g1_lo, input int g2_lo);
    if (bit_idx >= g2_lo) return 2;
    if (bit_idx >= g1_lo) return 1;
    return 0;
  endfunction
endpackage

// File: rtl/pmc_dly_timer.sv
module pmc_dly_timer #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             expired
);
  logic [DLY_W-1:0] cnt;
  logic             armed;

  assign expired = armed && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= load_val - DLY_W'(1);
      armed <= 1'b1;
    end else if (expired) begin
      armed <= 1'b0;
    end else if (armed) begin
      cnt <= cnt - DLY_W'(1);
    end
  end
endmodule

// File: rtl/pmc_seq_fsm.sv
module pmc_seq_fsm
  import pmc_pkg::*;
#(
  parameter int DLY_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req,
  input  logic [DLY_W-1:0]   d_io_off,
  input  logic [DLY_W-1:0]   d_clk_off,
  input  logic [DLY_W-1:0]   d_clk_on,
  input  logic [DLY_W-1:0]   d_io_on,
  input  logic               tmr_expired,
  output logic               tmr_load,
  output logic [DLY_W-1:0]   tmr_val,
  output logic [NUM_GRP-1:0] grp_on,
  output logic               ioe,
  output logic               sleep_status,
  output pmc_state_e         state,
  output logic               start_entry,
  output logic               start_exit
);
  localparam int RAMP_W = $clog2(NUM_GRP);
  localparam logic [RAMP_W-1:0] RAMP_LAST = RAMP_W'(NUM_GRP - 1);

  pmc_phase_e        phase;
  logic [RAMP_W-1:0] ramp_idx;
  logic              ramp_last;
  logic              load_t2;
  logic              load_t4;

  assign ramp_last   = (ramp_idx == RAMP_LAST);
  assign start_entry = (state == ST_AWAKE) && sleep_req;
  assign start_exit  = (state == ST_SLEEP) && !sleep_req;
  assign load_t2     = (state == ST_ENTER) && (phase == PH_WAIT_A) && tmr_expired;
  assign load_t4     = (state == ST_EXIT) && (phase == PH_RAMP) && ramp_last;
  assign tmr_load    = start_entry || start_exit || load_t2 || load_t4;

  always_comb begin
    tmr_val = d_io_off;
    if (start_exit) tmr_val = d_clk_on;
    else if (load_t2) tmr_val = d_clk_off;
    else if (load_t4) tmr_val = d_io_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_AWAKE;
      phase        <= PH_WAIT_A;
      ramp_idx     <= '0;
      grp_on       <= '1;
      ioe          <= 1'b1;
      sleep_status <= 1'b0;
    end else begin
      unique case (state)
        ST_AWAKE: if (sleep_req) begin
          state        <= ST_ENTER;
          phase        <= PH_WAIT_A;
          sleep_status <= 1'b1;
        end
        ST_ENTER: begin
          if (phase == PH_WAIT_A) begin
            if (tmr_expired) begin
              ioe   <= 1'b0;
              phase <= PH_WAIT_B;
            end
          end else if (phase == PH_WAIT_B) begin
            if (tmr_expired) begin
              grp_on[0] <= 1'b0;
              phase     <= PH_RAMP;
              ramp_idx  <= RAMP_W'(1);
            end
          end else begin
            for (int g = 1; g < NUM_GRP; g++)
              if (RAMP_W'(g) == ramp_idx) grp_on[g] <= 1'b0;
            ramp_idx <= ramp_idx + RAMP_W'(1);
            if (ramp_last) state <= ST_SLEEP;
          end
        end
        ST_SLEEP: if (!sleep_req) begin
          state <= ST_EXIT;
          phase <= PH_WAIT_A;
        end
        ST_EXIT: begin
          if (phase == PH_WAIT_A) begin
            if (tmr_expired) begin
              grp_on[0] <= 1'b1;
              phase     <= PH_RAMP;
              ramp_idx  <= RAMP_W'(1);
            end
          end else if (phase == PH_RAMP) begin
            for (int g = 1; g < NUM_GRP; g++)
              if (RAMP_W'(g) == ramp_idx) grp_on[g] <= 1'b1;
            ramp_idx <= ramp_idx + RAMP_W'(1);
            if (ramp_last) phase <= PH_WAIT_B;
          end else begin
            if (tmr_expired) begin
              ioe          <= 1'b1;
              sleep_status <= 1'b0;
              state        <= ST_AWAKE;
            end
          end
        end
        default: state <= ST_AWAKE;
      endcase
    end
  end
endmodule

// File: rtl/pmc_ena_fanout.sv
module pmc_ena_fanout
  import pmc_pkg::*;
#(
  parameter int NUM_EN = 16,
  parameter int G1_LO  = 6,
  parameter int G2_LO  = 11
) (
  input  logic [NUM_GRP-1:0] grp_on,
  output logic [NUM_EN-1:0]  clk_ena
);
  for (genvar b = 0; b < NUM_EN; b++) begin : g_bit
    localparam int GRP = group_of(b, G1_LO, G2_LO);
    assign clk_ena[b] = grp_on[GRP];
  end
endmodule

// File: rtl/pmc_sleep_ctrl.sv
module pmc_sleep_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_EN     = 16,
  parameter int DLY_W      = 6,
  parameter int G1_LO      = 6,
  parameter int G2_LO      = 11,
  parameter int MIN_IO_OFF = 1,
  parameter int MIN_CLK_OFF = 11,
  parameter int MIN_CLK_ON = 1,
  parameter int MIN_IO_ON  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic [DLY_W-1:0]  t_io_off,
  input  logic [DLY_W-1:0]  t_clk_off,
  input  logic [DLY_W-1:0]  t_clk_on,
  input  logic [DLY_W-1:0]  t_io_on,
  output logic [NUM_EN-1:0] clk_ena,
  output logic              ioe,
  output logic              sleep_status
);
  function automatic logic [DLY_W-1:0] raise_to(input logic [DLY_W-1:0] v, input int lo);
    logic [DLY_W-1:0] floor_v;
    floor_v = DLY_W'(lo);
    return (v < floor_v) ? floor_v : v;
  endfunction

  logic [DLY_W-1:0]   d_io_off, d_clk_off, d_clk_on, d_io_on;
  logic               tmr_load, tmr_expired;
  logic [DLY_W-1:0]   tmr_val;
  logic [NUM_GRP-1:0] grp_on;
  pmc_state_e         state;
  logic               start_entry, start_exit;

  assign d_io_off  = raise_to(t_io_off, MIN_IO_OFF);
  assign d_clk_off = raise_to(t_clk_off, MIN_CLK_OFF);
  assign d_clk_on  = raise_to(t_clk_on, MIN_CLK_ON);
  assign d_io_on   = raise_to(t_io_on, MIN_IO_ON);

  pmc_dly_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  pmc_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .d_io_off     (d_io_off),
    .d_clk_off    (d_clk_off),
    .d_clk_on     (d_clk_on),
    .d_io_on      (d_io_on),
    .tmr_expired  (tmr_expired),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .grp_on       (grp_on),
    .ioe          (ioe),
    .sleep_status (sleep_status),
    .state        (state),
    .start_entry  (start_entry),
    .start_exit   (start_exit)
  );

  pmc_ena_fanout #(.NUM_EN(NUM_EN), .G1_LO(G1_LO), .G2_LO(G2_LO)) u_fan (
    .grp_on  (grp_on),
    .clk_ena (clk_ena)
  );
endmodule

// File: rtl/pmc_sleep_ctrl_chk.sv
module pmc_sleep_ctrl_chk
  import pmc_pkg::*;
#(
  parameter int NUM_EN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_req,
  input logic [NUM_EN-1:0] clk_ena,
  input logic              ioe,
  input logic              sleep_status,
  input pmc_state_e        state,
  input logic              start_entry,
  input logic              start_exit
);
  logic [NUM_EN-1:0] off_v;
  assign off_v = ~clk_ena;

  assert_awake_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AWAKE) |-> (&clk_ena && ioe && !sleep_status));
  assert_sleep_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |-> (clk_ena == '0 && !ioe && sleep_status));
  assert_awake_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AWAKE && !sleep_req) |=> (state == ST_AWAKE));
  assert_sleep_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && sleep_req) |=> (state == ST_SLEEP));
  assert_entry_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_entry |=> (state == ST_ENTER && sleep_status));
  assert_exit_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_exit |=> (state == ST_EXIT && clk_ena == '0));
  assert_entry_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTER) |-> ((off_v & (off_v + 1'b1)) == '0));
  assert_exit_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXIT) |-> ((clk_ena & (clk_ena + 1'b1)) == '0));
  assert_status_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_status) |-> (state == ST_ENTER && ioe && &clk_ena));
  assert_status_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_status) |-> (state == ST_AWAKE && ioe && &clk_ena));
  assert_enter_ignores_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTER) |=> (state == ST_ENTER || state == ST_SLEEP));
  assert_exit_ignores_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXIT) |=> (state == ST_EXIT || state == ST_AWAKE));
  assert_io_off_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ioe) |-> &clk_ena);
  assert_clk_on_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ioe) |-> &clk_ena);
endmodule

bind pmc_sleep_ctrl pmc_sleep_ctrl_chk #(.NUM_EN(NUM_EN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_req    (sleep_req),
  .clk_ena      (clk_ena),
  .ioe          (ioe),
  .sleep_status (sleep_status),
  .state        (state),
  .start_entry  (start_entry),
  .start_exit   (start_exit)
);

// File: tb/tb_pmc_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_pmc_sleep_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_req = 1'b0;
  logic [5:0]  t1 = 6'd3, t2 = 6'd12, t3 = 6'd2, t4 = 6'd41;
  logic [15:0] clk_ena;
  logic        ioe, sleep_status;

  int    checks = 0, failures = 0;
  bit    done = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  pmc_sleep_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .t_io_off(t1), .t_clk_off(t2), .t_clk_on(t3), .t_io_on(t4),
    .clk_ena(clk_ena), .ioe(ioe), .sleep_status(sleep_status)
  );

  // behavioural reference: 0 awake, 1 entering, 2 asleep, 3 exiting
  int          m_st = 0;
  longint      cyc = 0, base = 0;
  int          e1, e2, e3, e4;
  logic [15:0] m_ena = 16'hFFFF;
  logic        m_ioe = 1'b1, m_stat = 1'b0;

  function automatic int floor_of(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; cyc = 0; m_ena = 16'hFFFF; m_ioe = 1'b1; m_stat = 1'b0;
    end else begin
      cyc++;
      if (m_st == 0) begin
        if (sleep_req) begin
          m_st = 1; base = cyc; m_stat = 1'b1;
          e1 = floor_of(int'(t1), 1); e2 = floor_of(int'(t2), 11);
        end
      end else if (m_st == 1) begin
        if (cyc == base + e1) m_ioe = 1'b0;
        if (cyc == base + e1 + e2) m_ena = m_ena & ~16'h003F;
        if (cyc == base + e1 + e2 + 1) m_ena = m_ena & ~16'h07C0;
        if (cyc == base + e1 + e2 + 2) begin m_ena = 16'h0000; m_st = 2; end
      end else if (m_st == 2) begin
        if (!sleep_req) begin
          m_st = 3; base = cyc;
          e3 = floor_of(int'(t3), 1); e4 = floor_of(int'(t4), 40);
        end
      end else begin
        if (cyc == base + e3) m_ena = m_ena | 16'h003F;
        if (cyc == base + e3 + 1) m_ena = m_ena | 16'h07C0;
        if (cyc == base + e3 + 2) m_ena = 16'hFFFF;
        if (cyc == base + e3 + 2 + e4) begin m_ioe = 1'b1; m_stat = 1'b0; m_st = 0; end
      end
    end
  end

  function automatic string step_tag(input int st);
    case (st)
      1: return "R3";
      2: return "R2";
      3: return "R4";
      default: return "R2";
    endcase
  endfunction

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      string t;
      t = rst_n ? {tag, "/", step_tag(m_st)} : "R1";
      checks++;
      if (clk_ena !== m_ena) begin
        failures++;
        $display("FAIL %s clk_ena actual=%h expected=%h cycle=%0d", t, clk_ena, m_ena, cyc);
      end
      checks++;
      if (ioe !== m_ioe) begin
        failures++;
        $display("FAIL %s R8 ioe actual=%b expected=%b cycle=%0d", t, ioe, m_ioe, cyc);
      end
      checks++;
      if (sleep_status !== m_stat) begin
        failures++;
        $display("FAIL %s R5 sleep_status actual=%b expected=%b cycle=%0d", t, sleep_status, m_stat, cyc);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic full_cycle(input int hold_sleep, input int hold_awake);
    @(negedge clk) sleep_req = 1'b1;
    wait_cyc(hold_sleep);
    @(negedge clk) sleep_req = 1'b0;
    wait_cyc(hold_awake);
  endtask

  initial begin
    wait_cyc(3);
    tag = "R1";
    checks++;
    if (clk_ena !== 16'hFFFF || ioe !== 1'b1 || sleep_status !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%h/%b/%b expected=ffff/1/0", clk_ena, ioe, sleep_status);
    end
    @(negedge clk) rst_n = 1'b1;
    tag = "R2"; wait_cyc(40);

    tag = "R3"; full_cycle(90, 120);

    tag = "R6"; t1 = 6'd0; t2 = 6'd0; t3 = 6'd0; t4 = 6'd0;
    wait_cyc(2);
    full_cycle(40, 80);
    t1 = 6'd5; t2 = 6'd10; t3 = 6'd7; t4 = 6'd39;
    full_cycle(40, 80);
    t1 = 6'd63; t2 = 6'd63; t3 = 6'd63; t4 = 6'd63;
    full_cycle(200, 200);

    tag = "R7"; t1 = 6'd4; t2 = 6'd11; t3 = 6'd3; t4 = 6'd40;
    wait_cyc(2);
    @(negedge clk) sleep_req = 1'b1;
    wait_cyc(2);
    @(negedge clk) sleep_req = 1'b0;
    wait_cyc(120);
    full_cycle(30, 5);
    @(negedge clk) sleep_req = 1'b1;
    wait_cyc(150);
    @(negedge clk) sleep_req = 1'b0;
    wait_cyc(120);

    tag = "R4"; t3 = 6'd1; t4 = 6'd40;
    full_cycle(25, 60);

    tag = "R2"; wait_cyc(30);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule